// File: doc/BRIEF.md
# Multi-Mode Asynchronous Serial Receiver

This block turns a serial receive line into bytes. It runs in one of three frame formats. The first is an 8-bit format, where the eighth bit can instead be checked as even parity. The other two are 9-bit formats meant for addressing in multiprocessor links. A one-cycle pulse `tick_i` arrives sixteen times per bit period and paces the sampling. A high-to-low transition on the line, seen while reception is enabled, starts a frame and restarts the receiver's own bit timing. Because of that restart, the receiver needs the same bit rate as the far transmitter but not the same phase.

Each bit is read near its centre by a majority vote of three oversamples. Just before the stop bit ends, the block does four things together: it loads the received byte and the ninth bit, raises a sticky completion flag, optionally raises a sticky parity-error flag, and may emit a one-cycle interrupt pulse. Whether the pulse fires depends on the format: in the gated 9-bit format it fires only when the ninth bit is 1. Dropping the enable stops a frame in progress and keeps the block idle.

Top module: `mmode_uart_rx`

## Requirements
- R1: While `rx_en_i` is 1 and the receiver is idle, a falling edge on the synchronised `rxd_i` starts a frame and sets the tick count of the start bit to zero at that edge. All later bit timing in the frame is counted from that edge.
- R2: Each bit spans 16 ticks, counted 0 to 15. The bit value is the majority of the line samples taken at ticks 7, 8 and 9. Data bits arrive least significant first, so the first data bit ends up in `data_o[0]`.
- R3: When `rx_en_i` is 0, a frame in progress is aborted and no new frame starts. An aborted or blocked frame changes no output.
- R4: `mode_i` selects the format. 2'b00 is 8 data bits. 2'b01 is 9 bits, gated. 2'b10 and 2'b11 are 9 bits, ungated. In the 9-bit formats the first eight bits go to `data_o` and the ninth bit goes to `bit9_o`.
- R5: When `mode_i`=2'b00 and `par_en_i`=1, the eighth received bit is even parity over the first seven. On a mismatch `par_err_o` is set and stays set. The byte, including the parity bit in `data_o[7]`, is still stored, and `rx_done_o` is still set.
- R6: `irq_o` is a one-cycle pulse issued when a frame completes. In the gated 9-bit format it is issued only if the ninth bit is 1. In the other formats it is issued after every frame.
- R7: `data_o`, `bit9_o`, `rx_done_o` and `par_err_o` update on the same clock, at tick 14 of the stop bit, before that bit ends. The value of the stop bit is not checked.
- R8: If the vote of the start bit is 1, the event counts as a glitch. The receiver returns to idle and no output changes.
- R9: `clr_i` clears `rx_done_o` and `par_err_o`. If a frame completes in the same cycle, the completion wins.
- R10: After reset all outputs are 0. After an 8-bit frame `bit9_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Oversampling tick, 16 per bit |
| rxd_i | input | 1 | Serial receive line, idle high |
| rx_en_i | input | 1 | Receive enable |
| mode_i | input | 2 | Frame format select |
| par_en_i | input | 1 | Parity check in 8-bit format |
| clr_i | input | 1 | Clear completion and parity-error flags |
| data_o | output | 8 | Received byte |
| bit9_o | output | 1 | Received ninth bit |
| par_err_o | output | 1 | Sticky parity error |
| rx_done_o | output | 1 | Sticky receive-complete flag |
| irq_o | output | 1 | Interrupt pending pulse |

## Verification
The hardest cases to reach are the ones where bit timing hangs on exact edge placement. One is a start pulse that lasts only a few ticks. Another is an enable that drops partway through the data bits. A third is a frame that begins at an arbitrary phase of the tick stream. To reach them, the bench drives the line at clock granularity and inserts idle gaps of varying length, so that start edges land at different offsets from the ticks. It issues deliberately short low pulses and cuts the enable in the middle of a frame. A behavioural model that runs every cycle follows each of these runs, and checks per frame confirm the stored byte, the ninth bit and the flags.

// File: rtl/mmode_uart_rx_pkg.sv
package mmode_uart_rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } rx_state_e;

  localparam logic [1:0] MODE_BYTE = 2'b00;
  localparam logic [1:0] MODE_GATE = 2'b01;
endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rxd_i,
  output logic line_o,
  output logic fall_o
);
  logic [STAGES:0] chain_q;

  genvar g;
  generate
    for (g = 0; g <= STAGES; g++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[g] <= 1'b1;
        else if (g == 0) chain_q[g] <= rxd_i;
        else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign line_o = chain_q[STAGES-1];
  assign fall_o = chain_q[STAGES] & ~chain_q[STAGES-1];
endmodule

// File: rtl/rx_bit_sampler.sv
module rx_bit_sampler #(
  parameter int OSR  = 16,
  parameter int MID  = 8,
  parameter int DONE = 14
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic run_i,
  input  logic restart_i,
  input  logic line_i,
  output logic vote_stb_o,
  output logic vote_o,
  output logic done_stb_o,
  output logic end_stb_o
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] C_PRE  = CW'(MID - 1);
  localparam logic [CW-1:0] C_MID  = CW'(MID);
  localparam logic [CW-1:0] C_POST = CW'(MID + 1);
  localparam logic [CW-1:0] C_DONE = CW'(DONE);
  localparam logic [CW-1:0] C_LAST = CW'(OSR - 1);

  logic [CW-1:0] cnt_q;
  logic          smp_a_q, smp_b_q;
  logic          step;

  assign step = run_i & tick_i & ~restart_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      smp_a_q <= 1'b1;
      smp_b_q <= 1'b1;
    end else if (restart_i) begin
      cnt_q <= '0;
    end else if (step) begin
      cnt_q <= (cnt_q == C_LAST) ? '0 : cnt_q + 1'b1;
      if (cnt_q == C_PRE) smp_a_q <= line_i;
      if (cnt_q == C_MID) smp_b_q <= line_i;
    end
  end

  assign vote_stb_o = step && (cnt_q == C_POST);
  assign vote_o     = (smp_a_q & smp_b_q) | (smp_a_q & line_i) | (smp_b_q & line_i);
  assign done_stb_o = step && (cnt_q == C_DONE);
  assign end_stb_o  = step && (cnt_q == C_LAST);
endmodule

// File: rtl/rx_frame_store.sv
module rx_frame_store #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          commit_i,
  input  logic          clr_i,
  input  logic [1:0]    mode_i,
  input  logic          par_en_i,
  input  logic [DW:0]   shreg_i,
  output logic [DW-1:0] data_o,
  output logic          bit9_o,
  output logic          par_err_o,
  output logic          rx_done_o,
  output logic          irq_o
);
  import mmode_uart_rx_pkg::*;

  logic          byte_mode;
  logic [DW-1:0] byte_nx;
  logic          b9_nx, perr_nx, irq_nx;

  always_comb begin
    byte_mode = (mode_i == MODE_BYTE);
    if (byte_mode) begin
      byte_nx = shreg_i[DW:1];
      b9_nx   = 1'b0;
      perr_nx = par_en_i & (^shreg_i[DW:1]);
      irq_nx  = 1'b1;
    end else begin
      byte_nx = shreg_i[DW-1:0];
      b9_nx   = shreg_i[DW];
      perr_nx = 1'b0;
      irq_nx  = (mode_i == MODE_GATE) ? shreg_i[DW] : 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o    <= '0;
      bit9_o    <= 1'b0;
      par_err_o <= 1'b0;
      rx_done_o <= 1'b0;
      irq_o     <= 1'b0;
    end else begin
      irq_o <= commit_i & irq_nx;
      if (commit_i) begin
        data_o    <= byte_nx;
        bit9_o    <= b9_nx;
        rx_done_o <= 1'b1;
        par_err_o <= perr_nx | (par_err_o & ~clr_i);
      end else if (clr_i) begin
        rx_done_o <= 1'b0;
        par_err_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mmode_uart_rx.sv
module mmode_uart_rx #(
  parameter int DW       = 8,
  parameter int OSR      = 16,
  parameter int SYNC_STG = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          rxd_i,
  input  logic          rx_en_i,
  input  logic [1:0]    mode_i,
  input  logic          par_en_i,
  input  logic          clr_i,
  output logic [DW-1:0] data_o,
  output logic          bit9_o,
  output logic          par_err_o,
  output logic          rx_done_o,
  output logic          irq_o
);
  import mmode_uart_rx_pkg::*;

  localparam int MID  = OSR / 2;
  localparam int DONE = OSR - 2;
  localparam int IW   = $clog2(DW + 2);

  rx_state_e     state_q;
  logic [IW-1:0] idx_q;
  logic [DW:0]   shreg_q;
  logic          line, fall, start_go, commit;
  logic          vote_stb, vote, done_stb, end_stb;
  logic [IW-1:0] nbits;

  assign nbits    = (mode_i == MODE_BYTE) ? IW'(DW) : IW'(DW + 1);
  assign start_go = (state_q == ST_IDLE) & rx_en_i & fall;
  assign commit   = (state_q == ST_STOP) & rx_en_i & done_stb;

  rx_line_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rxd_i  (rxd_i),
    .line_o (line),
    .fall_o (fall)
  );

  rx_bit_sampler #(.OSR(OSR), .MID(MID), .DONE(DONE)) u_smp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .run_i      (state_q != ST_IDLE && rx_en_i),
    .restart_i  (start_go),
    .line_i     (line),
    .vote_stb_o (vote_stb),
    .vote_o     (vote),
    .done_stb_o (done_stb),
    .end_stb_o  (end_stb)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      shreg_q <= '0;
    end else if (start_go) begin
      state_q <= ST_START;
      idx_q   <= '0;
    end else if (!rx_en_i) begin
      state_q <= ST_IDLE;
    end else begin
      unique case (state_q)
        ST_START: begin
          if (vote_stb && vote) state_q <= ST_IDLE;
          else if (end_stb) state_q <= ST_DATA;
        end
        ST_DATA: begin
          if (vote_stb) begin
            shreg_q <= {vote, shreg_q[DW:1]};
            idx_q   <= idx_q + 1'b1;
          end
          if (end_stb && idx_q == nbits) state_q <= ST_STOP;
        end
        ST_STOP: if (done_stb) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  rx_frame_store #(.DW(DW)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .commit_i  (commit),
    .clr_i     (clr_i),
    .mode_i    (mode_i),
    .par_en_i  (par_en_i),
    .shreg_i   (shreg_q),
    .data_o    (data_o),
    .bit9_o    (bit9_o),
    .par_err_o (par_err_o),
    .rx_done_o (rx_done_o),
    .irq_o     (irq_o)
  );
endmodule

// File: rtl/mmode_uart_rx_chk.sv
module mmode_uart_rx_chk #(
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rx_en_i,
  input logic [1:0]    mode_i,
  input logic          par_en_i,
  input logic [DW-1:0] data_o,
  input logic          bit9_o,
  input logic          par_err_o,
  input logic          rx_done_o,
  input logic          irq_o
);
  p_irq_with_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> rx_done_o);

  p_irq_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  p_gated_irq_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && mode_i == 2'b01) |-> bit9_o);

  p_data_with_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(data_o) |-> rx_done_o);

  p_no_done_disabled_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_done_o) |-> $past(rx_en_i));

  p_perr_byte_mode_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(par_err_o) |-> ($past(mode_i) == 2'b00 && $past(par_en_i)));

  p_b9_byte_mode_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(rx_done_o) && $past(mode_i) == 2'b00) |-> !bit9_o);
endmodule

bind mmode_uart_rx mmode_uart_rx_chk #(.DW(DW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rx_en_i   (rx_en_i),
  .mode_i    (mode_i),
  .par_en_i  (par_en_i),
  .data_o    (data_o),
  .bit9_o    (bit9_o),
  .par_err_o (par_err_o),
  .rx_done_o (rx_done_o),
  .irq_o     (irq_o)
);

// File: tb/mmode_uart_rx_test.sv
module mmode_uart_rx_test;
  localparam int TP  = 4;
  localparam int BIT = 16 * TP;

  logic       clk = 0, rst_n = 0, tick = 0, rxd = 1, en = 0, par_en = 0, clr = 0;
  logic [1:0] mode = 2'b00;
  logic [7:0] data;
  logic       b9, perr, done, irq;
  int         n_cmp = 0, n_bad = 0, tcnt = 0, irq_seen = 0;
  bit         fin = 0;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    tcnt <= (tcnt + 1) % TP;
    tick <= (tcnt == TP - 2);
  end

  mmode_uart_rx uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .rxd_i(rxd), .rx_en_i(en),
    .mode_i(mode), .par_en_i(par_en), .clr_i(clr), .data_o(data), .bit9_o(b9),
    .par_err_o(perr), .rx_done_o(done), .irq_o(irq)
  );

  // behavioural reference
  int   m_st, m_cnt, m_idx;
  bit   h1, h2, h3, sa, sb;
  bit [8:0] m_sh;
  bit [7:0] m_data;
  bit   m_b9, m_perr, m_done, m_irq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_idx = 0; h1 = 1; h2 = 1; h3 = 1; sa = 1; sb = 1;
      m_sh = 0; m_data = 0; m_b9 = 0; m_perr = 0; m_done = 0; m_irq = 0;
    end else begin
      automatic int nb = (mode == 2'b00) ? 8 : 9;
      automatic bit ln = h2;
      automatic bit v;
      m_irq = 0;
      if (clr) begin m_done = 0; m_perr = 0; end
      if (m_st == 0) begin
        if (en && h3 && !h2) begin m_st = 1; m_cnt = 0; m_idx = 0; end
      end else if (!en) begin
        m_st = 0;
      end else if (tick) begin
        if (m_cnt == 7) sa = ln;
        if (m_cnt == 8) sb = ln;
        if (m_cnt == 9) begin
          v = (int'(sa) + int'(sb) + int'(ln)) >= 2;
          if (m_st == 1 && v) m_st = 0;
          else if (m_st == 2) begin m_sh = {v, m_sh[8:1]}; m_idx++; end
        end
        if (m_cnt == 14 && m_st == 3) begin
          m_done = 1;
          if (mode == 2'b00) begin
            m_data = m_sh[8:1]; m_b9 = 0; m_irq = 1;
            if (par_en && (^m_sh[8:1])) m_perr = 1;
          end else begin
            m_data = m_sh[7:0]; m_b9 = m_sh[8];
            m_irq = (mode == 2'b01) ? m_sh[8] : 1'b1;
          end
          m_st = 0;
        end
        if (m_cnt == 15) begin
          if (m_st == 1) m_st = 2;
          else if (m_st == 2 && m_idx == nb) m_st = 3;
        end
        m_cnt = (m_cnt + 1) % 16;
      end
      h3 = h2; h2 = h1; h1 = rxd;
    end
  end

  always @(negedge clk) if (rst_n && !fin) begin
    n_cmp++;
    if ({data, b9, perr, done, irq} !== {m_data, m_b9, m_perr, m_done, m_irq}) begin
      n_bad++;
      $display("FAIL model R1 R2 R7: got d=%h b9=%b pe=%b dn=%b irq=%b exp d=%h b9=%b pe=%b dn=%b irq=%b",
               data, b9, perr, done, irq, m_data, m_b9, m_perr, m_done, m_irq);
    end
    if (irq) irq_seen++;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic frame(input logic [8:0] v, input int n, input int gap);
    repeat (gap) @(negedge clk);
    rxd = 0; repeat (BIT) @(negedge clk);
    for (int i = 0; i < n; i++) begin rxd = v[i]; repeat (BIT) @(negedge clk); end
    rxd = 1; repeat (BIT) @(negedge clk);
  endtask

  task automatic do_clr();
    @(negedge clk); clr = 1; @(negedge clk); clr = 0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 reset data", data, 0);
    chk("R10 reset flags", {b9, perr, done, irq}, 0);
    en = 1;

    // R2 R4 8-bit frames, LSB first, varying phase (R1)
    frame(9'h0A5, 8, 5);
    chk("R2 byte a5", data, 8'hA5);
    chk("R6 irq byte mode", irq_seen, 1);
    chk("R10 bit9 zero in byte mode", b9, 0);
    frame(9'h03C, 8, 2);
    chk("R1 byte 3c phase", data, 8'h3C);
    frame(9'h081, 8, 7);
    chk("R4 byte 81", data, 8'h81);

    // R9 clear
    do_clr();
    chk("R9 done cleared", done, 0);

    // R5 parity good (0x03 -> even, parity 0) and bad
    par_en = 1;
    frame(9'h003, 8, 3);
    chk("R5 parity ok", perr, 0);
    frame(9'h083, 8, 1);
    chk("R5 parity bad flag", perr, 1);
    chk("R5 data kept", data, 8'h83);
    chk("R5 done set", done, 1);
    frame(9'h003, 8, 6);
    chk("R5 sticky", perr, 1);
    do_clr();
    chk("R9 perr cleared", perr, 0);
    par_en = 0;

    // R4 R6 gated 9-bit
    mode = 2'b01; irq_seen = 0;
    frame(9'h055, 9, 4);
    chk("R6 gated no irq", irq_seen, 0);
    chk("R4 gated data", data, 8'h55);
    chk("R7 done without irq", done, 1);
    frame(9'h1AA, 9, 9);
    chk("R6 gated irq", irq_seen, 1);
    chk("R4 ninth bit", b9, 1);

    // ungated 9-bit
    mode = 2'b10; irq_seen = 0;
    frame(9'h012, 9, 2);
    frame(9'h1F0, 9, 5);
    chk("R6 always irq", irq_seen, 2);
    chk("R4 ungated data", {b9, data}, 9'h1F0);

    // R8 glitch start: short low pulse
    do_clr();
    repeat (3) @(negedge clk);
    rxd = 0; repeat (3 * TP) @(negedge clk); rxd = 1;
    repeat (3 * BIT) @(negedge clk);
    chk("R8 glitch no done", done, 0);
    chk("R8 glitch data unchanged", data, 8'hF0);

    // R3 abort mid-frame and disabled receiver
    irq_seen = 0;
    fork
      frame(9'h1FF, 9, 1);
      begin repeat (4 * BIT) @(negedge clk); en = 0; end
    join
    repeat (BIT) @(negedge clk);
    chk("R3 abort no done", done, 0);
    frame(9'h000, 9, 3);
    chk("R3 disabled no done", done, 0);
    chk("R3 disabled no irq", irq_seen, 0);
    chk("R3 data unchanged", data, 8'hF0);
    en = 1;
    frame(9'h166, 9, 8);
    chk("R3 reenabled", {b9, data}, 9'h166);

    fin = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule